// File: doc/BRIEF.md
# Oldest-First Squash Request Arbiter

This block sits at the end of an out-of-order core's execute stage. In each cycle several execute lanes can report a resolved branch that went the wrong way, or a memory-order violation found by the load/store logic. For every hardware thread the arbiter keeps only the request that would squash the oldest instruction, judged by sequence number. On the next clock edge it presents one squash record per thread to the commit stage. A record holds a pending flag, the squashing sequence number, the PC to fetch from next, the resolved branch direction and a flag that says whether the squashing instruction itself is thrown away.

The two causes are handled differently. A wrong branch keeps the branch and restarts fetch at the address after it. The lane supplies that address, because the PC adder is outside this block. A violation discards the violating load and refetches it from its own PC. When both causes name the same sequence number, the violation wins, because it squashes strictly more. Lanes are scanned in index order within a cycle, and once a thread holds an older squash, younger candidates are skipped. Three running counters record wrong branches that had been predicted taken, wrong branches that had been predicted not-taken, and violation events.

Top module: `squash_arbiter`

## Requirements
- R1: While `rst` is high, and on the first edge after it, every record output is 0 and all three counters read 0.
- R2: The record seen after a clock edge depends only on the lane inputs of the cycle just before that edge. A cycle with no accepted request gives a record with every field 0, including sequence number and PC.
- R3: A wrong-branch request (`lane_mispred`=1) installs itself when its thread has no record yet this cycle, or when its sequence number is strictly smaller than the held one. The record then shows valid=1, seq=lane seq, pc=`lane_npc`, taken=`lane_taken`, include=0.
- R4: A violation request (`lane_viol`=1, and not treated as a wrong branch) installs itself when its thread has no record yet this cycle, or when `lane_viol_seq` is smaller than or equal to the held sequence number. The record then shows valid=1, seq=`lane_viol_seq`, pc=`lane_viol_pc`, taken=0, include=1.
- R5: A violation whose violator sequence number equals that of a wrong branch already held for the same thread replaces the branch record.
- R6: A lane is considered only if its thread has taken no redirect yet this cycle, or has no record, or the held sequence number is strictly greater than the lane's own `lane_seq`. A lane that is not considered changes no record and no counter.
- R7: A lane with `lane_is_load`=1 and `lane_done`=0 is never treated as a wrong branch, even if `lane_mispred`=1. Such a lane is evaluated as a violation candidate instead.
- R8: Each wrong branch that is considered adds 1 to `cnt_taken_wrong` when `lane_pred_taken`=1, and otherwise adds 1 to `cnt_ntaken_wrong`. This happens whether or not the branch installs.
- R9: Each violation that is considered adds 1 to `cnt_viol`, even when an older record keeps it from installing.
- R10: Threads are independent. `lane_tid` selects the thread, and a record bit or field for thread t sits at index t of each packed output.
- R11: Lanes are resolved in ascending index order within a cycle. Lane i sees the record state left after lanes 0..i-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_valid | input | LANES | Lane carries a resolved instruction |
| lane_tid | input | LANES*TID_W | Thread of each lane |
| lane_seq | input | LANES*SEQ_W | Sequence number of each lane's instruction |
| lane_npc | input | LANES*PC_W | Address following the instruction |
| lane_mispred | input | LANES | Branch resolved against its prediction |
| lane_taken | input | LANES | Resolved branch direction |
| lane_pred_taken | input | LANES | Predicted direction |
| lane_is_load | input | LANES | Instruction is a load |
| lane_done | input | LANES | Instruction has finished executing |
| lane_viol | input | LANES | Memory-order violation reported on this lane |
| lane_viol_seq | input | LANES*SEQ_W | Sequence number of the violating load |
| lane_viol_pc | input | LANES*PC_W | PC of the violating load |
| sq_valid | output | THREADS | Squash pending per thread |
| sq_seq | output | THREADS*SEQ_W | Squashing sequence number per thread |
| sq_pc | output | THREADS*PC_W | Redirect PC per thread |
| sq_taken | output | THREADS | Branch direction of a branch squash |
| sq_incl | output | THREADS | Squashing instruction is itself squashed |
| cnt_taken_wrong | output | CNT_W | Wrong branches predicted taken |
| cnt_ntaken_wrong | output | CNT_W | Wrong branches predicted not-taken |
| cnt_viol | output | CNT_W | Violation events considered |

## Verification
Directed cycles cover the following cases:
- a lone branch and a lone violation, which separates the PC and include rules of the two causes;
- equal sequence numbers in both lane orders, which separates the two tie rules;
- an older branch against a younger violation, and a younger violation against an older branch, where the violation is counted but does not install;
- an unexecuted load that raises the wrong-branch flag, with and without a violation;
- two threads in one cycle;
- the same pair of branches in both lane orders, which shows that lane order changes the counters.

A long pseudo-random sweep then uses 4-bit sequence numbers, so ties and reorderings are frequent. It compares every record field and every counter, cycle by cycle, against a model written from the requirements.

// File: rtl/sq_pkg.sv
package sq_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_BRANCH = 2'd1,
        CAUSE_VIOL   = 2'd2
    } sq_cause_e;

    // A new request of the given cause replaces the held record.
    // Branches need a strictly older number; violations also win a tie.
    function automatic logic sq_takes_over(sq_cause_e cause,
                                           logic [63:0] cand,
                                           logic [63:0] held,
                                           logic held_v);
        if (!held_v)
            return 1'b1;
        if (cause == CAUSE_VIOL)
            return cand <= held;
        return cand < held;
    endfunction

    // A lane is looked at only when no redirect has been taken for its
    // thread, or nothing is held, or the held squash is younger.
    function automatic logic sq_gate_open(logic redir,
                                          logic held_v,
                                          logic [63:0] held,
                                          logic [63:0] lane);
        return !redir || !held_v || (held > lane);
    endfunction

endpackage

// File: rtl/sq_stage.sv
module sq_stage #(
    parameter int THREADS = 2,
    parameter int SEQ_W   = 4,
    parameter int PC_W    = 8,
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic                              l_valid,
    input  logic [TID_W-1:0]                  l_tid,
    input  logic [SEQ_W-1:0]                  l_seq,
    input  logic [PC_W-1:0]                   l_npc,
    input  logic                              l_mispred,
    input  logic                              l_taken,
    input  logic                              l_pred_taken,
    input  logic                              l_is_load,
    input  logic                              l_done,
    input  logic                              l_viol,
    input  logic [SEQ_W-1:0]                  l_viol_seq,
    input  logic [PC_W-1:0]                   l_viol_pc,
    input  logic [THREADS-1:0]                in_valid,
    input  logic [THREADS-1:0]                in_redir,
    input  logic [THREADS-1:0]                in_taken,
    input  logic [THREADS-1:0]                in_incl,
    input  logic [THREADS-1:0][SEQ_W-1:0]     in_seq,
    input  logic [THREADS-1:0][PC_W-1:0]      in_pc,
    output logic [THREADS-1:0]                out_valid,
    output logic [THREADS-1:0]                out_redir,
    output logic [THREADS-1:0]                out_taken,
    output logic [THREADS-1:0]                out_incl,
    output logic [THREADS-1:0][SEQ_W-1:0]     out_seq,
    output logic [THREADS-1:0][PC_W-1:0]      out_pc,
    output logic                              ev_pt_wrong,
    output logic                              ev_pnt_wrong,
    output logic                              ev_viol
);
    import sq_pkg::*;

    logic is_branch;
    logic gate;
    int   t;

    // Unexecuted loads cannot be judged as wrong branches.
    assign is_branch = l_mispred && !(l_is_load && !l_done);

    always_comb begin
        out_valid    = in_valid;
        out_redir    = in_redir;
        out_taken    = in_taken;
        out_incl     = in_incl;
        out_seq      = in_seq;
        out_pc       = in_pc;
        ev_pt_wrong  = 1'b0;
        ev_pnt_wrong = 1'b0;
        ev_viol      = 1'b0;
        gate         = 1'b0;
        t            = int'(l_tid);
        if (l_valid && (t < THREADS)) begin
            gate = sq_gate_open(in_redir[t], in_valid[t],
                                64'(in_seq[t]), 64'(l_seq));
            if (gate) begin
                if (is_branch) begin
                    out_redir[t] = 1'b1;
                    if (l_pred_taken)
                        ev_pt_wrong = 1'b1;
                    else
                        ev_pnt_wrong = 1'b1;
                    if (sq_takes_over(CAUSE_BRANCH, 64'(l_seq),
                                      64'(in_seq[t]), in_valid[t])) begin
                        out_valid[t] = 1'b1;
                        out_seq[t]   = l_seq;
                        out_pc[t]    = l_npc;
                        out_taken[t] = l_taken;
                        out_incl[t]  = 1'b0;
                    end
                end else if (l_viol) begin
                    out_redir[t] = 1'b1;
                    ev_viol      = 1'b1;
                    if (sq_takes_over(CAUSE_VIOL, 64'(l_viol_seq),
                                      64'(in_seq[t]), in_valid[t])) begin
                        out_valid[t] = 1'b1;
                        out_seq[t]   = l_viol_seq;
                        out_pc[t]    = l_viol_pc;
                        out_taken[t] = 1'b0;
                        out_incl[t]  = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sq_counter.sv
module sq_counter #(
    parameter int LANES = 3,
    parameter int CNT_W = 12,
    localparam int SUM_W = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] ev,
    output logic [CNT_W-1:0] cnt
);
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = '0;
        for (int i = 0; i < LANES; i++)
            sum = sum + SUM_W'(ev[i]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(sum);
    end

endmodule

// File: rtl/squash_arbiter.sv
module squash_arbiter #(
    parameter int LANES   = 3,
    parameter int THREADS = 2,
    parameter int SEQ_W   = 4,
    parameter int PC_W    = 8,
    parameter int CNT_W   = 12,
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LANES-1:0]          lane_valid,
    input  logic [LANES*TID_W-1:0]    lane_tid,
    input  logic [LANES*SEQ_W-1:0]    lane_seq,
    input  logic [LANES*PC_W-1:0]     lane_npc,
    input  logic [LANES-1:0]          lane_mispred,
    input  logic [LANES-1:0]          lane_taken,
    input  logic [LANES-1:0]          lane_pred_taken,
    input  logic [LANES-1:0]          lane_is_load,
    input  logic [LANES-1:0]          lane_done,
    input  logic [LANES-1:0]          lane_viol,
    input  logic [LANES*SEQ_W-1:0]    lane_viol_seq,
    input  logic [LANES*PC_W-1:0]     lane_viol_pc,
    output logic [THREADS-1:0]        sq_valid,
    output logic [THREADS*SEQ_W-1:0]  sq_seq,
    output logic [THREADS*PC_W-1:0]   sq_pc,
    output logic [THREADS-1:0]        sq_taken,
    output logic [THREADS-1:0]        sq_incl,
    output logic [CNT_W-1:0]          cnt_taken_wrong,
    output logic [CNT_W-1:0]          cnt_ntaken_wrong,
    output logic [CNT_W-1:0]          cnt_viol
);
    // Chain of per-thread record state; index 0 is the cleared start.
    logic [LANES:0][THREADS-1:0]            ch_valid;
    logic [LANES:0][THREADS-1:0]            ch_redir;
    logic [LANES:0][THREADS-1:0]            ch_taken;
    logic [LANES:0][THREADS-1:0]            ch_incl;
    logic [LANES:0][THREADS-1:0][SEQ_W-1:0] ch_seq;
    logic [LANES:0][THREADS-1:0][PC_W-1:0]  ch_pc;
    logic [LANES-1:0] ev_pt, ev_pnt, ev_v;

    assign ch_valid[0] = '0;
    assign ch_redir[0] = '0;
    assign ch_taken[0] = '0;
    assign ch_incl[0]  = '0;
    assign ch_seq[0]   = '0;
    assign ch_pc[0]    = '0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sq_stage #(.THREADS(THREADS), .SEQ_W(SEQ_W), .PC_W(PC_W)) u_stage (
            .l_valid      (lane_valid[i]),
            .l_tid        (lane_tid[i*TID_W +: TID_W]),
            .l_seq        (lane_seq[i*SEQ_W +: SEQ_W]),
            .l_npc        (lane_npc[i*PC_W +: PC_W]),
            .l_mispred    (lane_mispred[i]),
            .l_taken      (lane_taken[i]),
            .l_pred_taken (lane_pred_taken[i]),
            .l_is_load    (lane_is_load[i]),
            .l_done       (lane_done[i]),
            .l_viol       (lane_viol[i]),
            .l_viol_seq   (lane_viol_seq[i*SEQ_W +: SEQ_W]),
            .l_viol_pc    (lane_viol_pc[i*PC_W +: PC_W]),
            .in_valid     (ch_valid[i]),
            .in_redir     (ch_redir[i]),
            .in_taken     (ch_taken[i]),
            .in_incl      (ch_incl[i]),
            .in_seq       (ch_seq[i]),
            .in_pc        (ch_pc[i]),
            .out_valid    (ch_valid[i+1]),
            .out_redir    (ch_redir[i+1]),
            .out_taken    (ch_taken[i+1]),
            .out_incl     (ch_incl[i+1]),
            .out_seq      (ch_seq[i+1]),
            .out_pc       (ch_pc[i+1]),
            .ev_pt_wrong  (ev_pt[i]),
            .ev_pnt_wrong (ev_pnt[i]),
            .ev_viol      (ev_v[i])
        );
    end

    logic [THREADS-1:0]            rec_valid, rec_taken, rec_incl;
    logic [THREADS-1:0][SEQ_W-1:0] rec_seq;
    logic [THREADS-1:0][PC_W-1:0]  rec_pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_valid <= '0;
            rec_taken <= '0;
            rec_incl  <= '0;
            rec_seq   <= '0;
            rec_pc    <= '0;
        end else begin
            rec_valid <= ch_valid[LANES];
            rec_taken <= ch_taken[LANES];
            rec_incl  <= ch_incl[LANES];
            rec_seq   <= ch_seq[LANES];
            rec_pc    <= ch_pc[LANES];
        end
    end

    assign sq_valid = rec_valid;
    assign sq_taken = rec_taken;
    assign sq_incl  = rec_incl;
    assign sq_seq   = rec_seq;
    assign sq_pc    = rec_pc;

    sq_counter #(.LANES(LANES), .CNT_W(CNT_W)) u_cnt_pt (
        .clk(clk), .rst(rst), .ev(ev_pt), .cnt(cnt_taken_wrong));
    sq_counter #(.LANES(LANES), .CNT_W(CNT_W)) u_cnt_pnt (
        .clk(clk), .rst(rst), .ev(ev_pnt), .cnt(cnt_ntaken_wrong));
    sq_counter #(.LANES(LANES), .CNT_W(CNT_W)) u_cnt_viol (
        .clk(clk), .rst(rst), .ev(ev_v), .cnt(cnt_viol));

endmodule

// File: rtl/squash_arbiter_chk.sv
module squash_arbiter_chk #(
    parameter int LANES   = 3,
    parameter int THREADS = 2,
    parameter int CNT_W   = 12
) (
    input logic               clk,
    input logic               rst,
    input logic [LANES-1:0]   lane_valid,
    input logic [LANES-1:0]   lane_mispred,
    input logic [LANES-1:0]   lane_viol,
    input logic [THREADS-1:0] sq_valid,
    input logic [THREADS-1:0] sq_taken,
    input logic [THREADS-1:0] sq_incl,
    input logic [CNT_W-1:0]   cnt_taken_wrong,
    input logic [CNT_W-1:0]   cnt_ntaken_wrong,
    input logic [CNT_W-1:0]   cnt_viol
);
    logic [CNT_W-1:0] viol_prev;
    logic [CNT_W-1:0] viol_step;

    always_ff @(posedge clk) viol_prev <= cnt_viol;
    assign viol_step = cnt_viol - viol_prev;

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        // R4
        incl_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
            sq_incl[t] |-> sq_valid[t]);
        // R3
        taken_only_branch_chk: assert property (@(posedge clk) disable iff (rst)
            sq_taken[t] |-> (sq_valid[t] && !sq_incl[t]));
    end

    // R2
    idle_clears_record_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_valid == '0) |=> (sq_valid == '0));

    // R8
    idle_holds_counts_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_valid == '0) |=> ($stable(cnt_taken_wrong) && $stable(cnt_ntaken_wrong)
                                && $stable(cnt_viol)));

    // R9
    viol_step_bound_chk: assert property (@(posedge clk) disable iff (rst)
        viol_step <= CNT_W'(LANES));

    // R6
    no_cause_no_squash_chk: assert property (@(posedge clk) disable iff (rst)
        ((lane_valid & (lane_mispred | lane_viol)) == '0) |=> (sq_valid == '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (sq_valid == '0 && cnt_viol == '0));

endmodule

bind squash_arbiter squash_arbiter_chk #(
    .LANES(LANES), .THREADS(THREADS), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst),
    .lane_valid(lane_valid), .lane_mispred(lane_mispred), .lane_viol(lane_viol),
    .sq_valid(sq_valid), .sq_taken(sq_taken), .sq_incl(sq_incl),
    .cnt_taken_wrong(cnt_taken_wrong), .cnt_ntaken_wrong(cnt_ntaken_wrong),
    .cnt_viol(cnt_viol)
);

// File: tb/tb_squash_arbiter.sv
`timescale 1ns/1ps
module tb_squash_arbiter;
    localparam int L  = 3;
    localparam int T  = 2;
    localparam int SW = 4;
    localparam int PW = 8;
    localparam int CW = 12;
    localparam int TW = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [L-1:0]    v, mis, tk, ptk, ld, dn, vi;
    logic [L*TW-1:0] tid;
    logic [L*SW-1:0] seq, vseq;
    logic [L*PW-1:0] npc, vpc;

    logic [T-1:0]    sq_valid, sq_taken, sq_incl;
    logic [T*SW-1:0] sq_seq;
    logic [T*PW-1:0] sq_pc;
    logic [CW-1:0]   c_pt, c_pnt, c_v;

    squash_arbiter #(.LANES(L), .THREADS(T), .SEQ_W(SW), .PC_W(PW), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst),
        .lane_valid(v), .lane_tid(tid), .lane_seq(seq), .lane_npc(npc),
        .lane_mispred(mis), .lane_taken(tk), .lane_pred_taken(ptk),
        .lane_is_load(ld), .lane_done(dn), .lane_viol(vi),
        .lane_viol_seq(vseq), .lane_viol_pc(vpc),
        .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_pc(sq_pc),
        .sq_taken(sq_taken), .sq_incl(sq_incl),
        .cnt_taken_wrong(c_pt), .cnt_ntaken_wrong(c_pnt), .cnt_viol(c_v)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    int e_v[T], e_seq[T], e_pc[T], e_tk[T], e_inc[T];
    int e_cpt = 0, e_cpnt = 0, e_cv = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_lanes();
        v = '0; mis = '0; tk = '0; ptk = '0; ld = '0; dn = '0; vi = '0;
        tid = '0; seq = '0; vseq = '0; npc = '0; vpc = '0;
    endtask

    task automatic set_lane(input int i, input int th, input int s, input int np,
                            input bit m, input bit t_, input bit pt,
                            input bit isl, input bit d, input bit vv,
                            input int vs, input int vp);
        v[i] = 1'b1; tid[i*TW +: TW] = TW'(th); seq[i*SW +: SW] = SW'(s);
        npc[i*PW +: PW] = PW'(np); mis[i] = m; tk[i] = t_; ptk[i] = pt;
        ld[i] = isl; dn[i] = d; vi[i] = vv;
        vseq[i*SW +: SW] = SW'(vs); vpc[i*PW +: PW] = PW'(vp);
    endtask

    // Expected record from the requirements (R3..R11).
    task automatic model();
        int rd[T];
        for (int t = 0; t < T; t++) begin
            e_v[t] = 0; e_seq[t] = 0; e_pc[t] = 0; e_tk[t] = 0; e_inc[t] = 0; rd[t] = 0;
        end
        for (int i = 0; i < L; i++) begin
            int th, s, vs;
            bit br;
            if (!v[i]) continue;
            th = int'(tid[i*TW +: TW]);
            s  = int'(seq[i*SW +: SW]);
            vs = int'(vseq[i*SW +: SW]);
            if (!(rd[th] == 0 || e_v[th] == 0 || e_seq[th] > s)) continue;
            br = mis[i] && !(ld[i] && !dn[i]);
            if (br) begin
                rd[th] = 1;
                if (ptk[i]) e_cpt++; else e_cpnt++;
                if (e_v[th] == 0 || s < e_seq[th]) begin
                    e_v[th] = 1; e_seq[th] = s; e_pc[th] = int'(npc[i*PW +: PW]);
                    e_tk[th] = int'(tk[i]); e_inc[th] = 0;
                end
            end else if (vi[i]) begin
                rd[th] = 1;
                e_cv++;
                if (e_v[th] == 0 || vs <= e_seq[th]) begin
                    e_v[th] = 1; e_seq[th] = vs; e_pc[th] = int'(vpc[i*PW +: PW]);
                    e_tk[th] = 0; e_inc[th] = 1;
                end
            end
        end
        e_cpt &= (1 << CW) - 1; e_cpnt &= (1 << CW) - 1; e_cv &= (1 << CW) - 1;
    endtask

    task automatic compare(input string tag);
        for (int t = 0; t < T; t++) begin
            chk(tag, "valid", int'(sq_valid[t]), e_v[t]);
            chk(tag, "seq",   int'(sq_seq[t*SW +: SW]), e_seq[t]);
            chk(tag, "pc",    int'(sq_pc[t*PW +: PW]), e_pc[t]);
            chk(tag, "taken", int'(sq_taken[t]), e_tk[t]);
            chk(tag, "incl",  int'(sq_incl[t]), e_inc[t]);
        end
        chk(tag, "cnt_taken_wrong",  int'(c_pt),  e_cpt);
        chk(tag, "cnt_ntaken_wrong", int'(c_pnt), e_cpnt);
        chk(tag, "cnt_viol",         int'(c_v),   e_cv);
    endtask

    // Inputs are driven after a falling edge; the record is registered on the
    // rising edge, so it is sampled at the following falling edge.
    task automatic step(input string tag);
        model();
        @(negedge clk);
        compare(tag);
        clear_lanes();
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned lcg;
        clear_lanes();
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int t = 0; t < T; t++) begin
            e_v[t] = 0; e_seq[t] = 0; e_pc[t] = 0; e_tk[t] = 0; e_inc[t] = 0;
        end
        compare("R1");
        rst = 1'b0;

        // R3: lone branch, predicted not-taken, resolved taken
        set_lane(0, 0, 6, 8'h21, 1, 1, 0, 0, 1, 0, 0, 0);
        step("R3");
        chk("R3", "pc after branch", int'(sq_pc[0 +: PW]), 8'h21);

        // R4: lone violation on thread 1
        set_lane(0, 1, 3, 8'h10, 0, 0, 0, 0, 1, 1, 2, 8'h40);
        step("R4");
        chk("R4", "incl", int'(sq_incl[1]), 1);

        // R5: tie, violation after branch with equal number
        set_lane(0, 0, 9, 8'h11, 1, 0, 1, 0, 1, 0, 0, 0);
        set_lane(1, 0, 7, 8'h12, 0, 0, 0, 0, 1, 1, 9, 8'h55);
        step("R5");
        chk("R5", "pc tie", int'(sq_pc[0 +: PW]), 8'h55);

        // R6: tie in the other order, branch lane not considered
        set_lane(0, 0, 1, 8'h01, 0, 0, 0, 0, 1, 1, 5, 8'h33);
        set_lane(1, 0, 5, 8'h66, 1, 1, 1, 0, 1, 0, 0, 0);
        step("R6");
        // R6: younger branch behind held branch is ignored
        set_lane(0, 0, 4, 8'h44, 1, 1, 1, 0, 1, 0, 0, 0);
        set_lane(1, 0, 6, 8'h77, 1, 0, 0, 0, 1, 0, 0, 0);
        step("R6");

        // R3: older branch replaces a younger violation
        set_lane(0, 0, 2, 8'h02, 0, 0, 0, 0, 1, 1, 5, 8'h33);
        set_lane(1, 0, 3, 8'h3A, 1, 1, 0, 0, 1, 0, 0, 0);
        step("R3");

        // R7: unexecuted load flagged mispredicted, no violation
        set_lane(0, 0, 5, 8'h50, 1, 1, 1, 1, 0, 0, 0, 0);
        step("R7");
        // R7: same load with violation becomes a violation
        set_lane(0, 0, 5, 8'h50, 1, 1, 1, 1, 0, 1, 4, 8'h48);
        step("R7");

        // R9: violation counted though an older branch is kept
        set_lane(0, 0, 2, 8'h22, 1, 0, 0, 0, 1, 0, 0, 0);
        set_lane(1, 0, 1, 8'h99, 0, 0, 0, 0, 1, 1, 7, 8'h70);
        step("R9");

        // R10: both threads at once
        set_lane(0, 0, 8, 8'h81, 1, 1, 1, 0, 1, 0, 0, 0);
        set_lane(2, 1, 12, 8'hC1, 1, 0, 0, 0, 1, 0, 0, 0);
        step("R10");

        // R2: idle cycle clears everything
        step("R2");

        // R11: lane order changes counting
        set_lane(0, 0, 9, 8'h90, 1, 1, 1, 0, 1, 0, 0, 0);
        set_lane(1, 0, 5, 8'h50, 1, 1, 1, 0, 1, 0, 0, 0);
        step("R11");
        set_lane(0, 0, 5, 8'h50, 1, 1, 1, 0, 1, 0, 0, 0);
        set_lane(1, 0, 9, 8'h90, 1, 1, 1, 0, 1, 0, 0, 0);
        step("R11");

        // R8: pseudo-random sweep over all fields, counters and records
        lcg = 32'h1234_5678;
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < L; i++) begin
                int unsigned a, b;
                lcg = lcg * 32'd1664525 + 32'd1013904223; a = lcg;
                lcg = lcg * 32'd1664525 + 32'd1013904223; b = lcg;
                if (a[31:30] != 2'b00)
                    set_lane(i, int'(a[0]), int'(a[4:1]), int'(a[12:5]),
                             a[13], a[14], a[15], a[16], a[17] | a[18], a[19],
                             int'(b[3:0]), int'(b[11:4]));
            end
            step("R8");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule